// File: doc/BRIEF.md
# Data Translation Cache with Access Checks

This block holds recently used virtual-to-physical page translations for data accesses. It has 64 entries in 16 sets of 4 ways. A request gives a 20-bit virtual page number, a 12-bit page offset, the access kind (read or write) and the current privilege (user or supervisor). In the same cycle the block answers with one of three results: a translation (hit), a protection fault, or a request to the external page walker.

Each entry caches the merged rights of its mapping: supervisor-only, writable, global and dirty. The first write to a page whose cached dirty flag is clear does not complete. The block instead asks the walker to mark the page-table entry dirty. The walker then refills the entry with the dirty flag set. The walker delivers all fills through a single fill port.

Two maintenance commands remove entries. A single-page invalidate removes one mapping. A context-switch flush removes every mapping that is not marked global.

Top module: `dtlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any valid request gives walk_req=1, hit=0 and fault=0.
- R2: The set is chosen by vpn bits [3:0] and the tag is vpn bits [19:4]. Up to 4 pages with different tags can live in one set at the same time. On a hit, ppn is the cached physical page and paddr is {ppn, offset}.
- R3: A request whose page is not cached gives walk_req=1, hit=0 and fault=0.
- R4: A user access (req_user=1) to a supervisor-only entry, or a write to a non-writable entry, gives fault=1, hit=0 and walk_req=0. In that case ppn and paddr read 0. The fault takes priority over the dirty rule of R5.
- R5: A write to a cached, permitted entry whose dirty flag is clear gives walk_req=1 with hit=0 and fault=0. A read of the same entry hits. After the entry is refilled with dirty=1, the write hits.
- R6: A fill always writes one way of the set. If the page is already cached, its own way is overwritten. Otherwise the lowest-numbered invalid way is used. If the set is full, the way named by that set's 2-bit round-robin pointer is used, and the pointer then steps by one (modulo 4). The pointer moves only in that last case.
- R7: A single-page invalidate removes the matching entry, even when the entry is global.
- R8: A flush removes every non-global entry and keeps every global entry.
- R9: When commands arrive in the same cycle, only one takes effect, in this order: flush first, then invalidate, then fill.
- R10: With req_valid=0, hit, fault and walk_req are 0 and ppn and paddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | 20 | Virtual page number to translate |
| req_off | input | 12 | Page offset passed through to paddr |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| fill_valid | input | 1 | Install a translation from the walker |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| fill_global | input | 1 | Entry survives a flush |
| fill_super | input | 1 | Entry is supervisor-only |
| fill_writable | input | 1 | Entry allows writes |
| fill_dirty | input | 1 | Page-table entry already marked dirty |
| inv_page | input | 1 | Invalidate the page named by inv_vpn |
| inv_vpn | input | 20 | Page to invalidate |
| flush_all | input | 1 | Remove all non-global entries |
| hit | output | 1 | Translation returned |
| ppn | output | 20 | Physical page number (0 unless hit) |
| paddr | output | 32 | Physical address (0 unless hit) |
| fault | output | 1 | Protection violation |
| walk_req | output | 1 | Walker needed (miss or dirty update) |

## Verification
The replacement test fills one set past its capacity. It then invalidates a middle way and fills twice more. A design that ignored invalid ways, or that moved the pointer on every fill, would evict the wrong page, and a surviving page would miss.

A write to a clean page, and a write to a clean page that is also read-only, separate the dirty-walk result from the fault result. A design with the wrong priority would start a walk where it should raise a fault.

Same-cycle command collisions and a flush over global and non-global pages show whether the global flag is honoured by the flush but ignored by the single-page invalidate.

// File: rtl/dtlb_pkg.sv
// Shared constants and the entry layout for the data translation cache.
// Assumes 4 KB pages, a 20-bit virtual and physical page number.
package dtlb_pkg;
    localparam int VPN_W    = 20;
    localparam int PPN_W    = 20;
    localparam int OFF_W    = 12;
    localparam int SET_BITS = 4;
    localparam int TAG_W    = VPN_W - SET_BITS;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             sup;
        logic             wr;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } entry_t;
endpackage

// File: rtl/dtlb_match.sv
// Tag comparator for one set: flags each valid way whose tag equals tag_i.
// Assumes a set never holds two valid entries with the same tag.
module dtlb_match
    import dtlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  entry_t [WAYS-1:0] ways_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic [WAYS-1:0]   hit_oh
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        // per-way compare of tag and valid bit
        assign hit_oh[w] = ways_i[w].valid && (ways_i[w].tag == tag_i);
    end
endmodule

// File: rtl/dtlb_victim.sv
// Way chooser for fills: the way already holding the page, else the lowest
// free way, else the set's round-robin pointer, which then advances.
// Assumes fill_go is high for exactly the cycle the fill is written.
module dtlb_victim
    import dtlb_pkg::*;
#(
    parameter int WAY_BITS = 2,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int SETS = 1 << SET_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_go,
    input  logic [SET_BITS-1:0] fill_set,
    input  logic [WAYS-1:0]     match_oh,
    input  logic [WAYS-1:0]     empty_oh,
    output logic [WAY_BITS-1:0] way_idx
);
    logic [WAY_BITS-1:0] ptr [SETS];
    logic has_match, has_free;

    assign has_match = |match_oh;
    assign has_free  = |empty_oh;

    // pick the way: matching way over lowest free way over pointer
    always_comb begin
        way_idx = ptr[fill_set];
        for (int w = WAYS - 1; w >= 0; w--)
            if (empty_oh[w]) way_idx = WAY_BITS'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (match_oh[w]) way_idx = WAY_BITS'(w);
    end

    // advance the set pointer only when it chose the victim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (fill_go && !has_match && !has_free) begin
            ptr[fill_set] <= ptr[fill_set] + 1'b1;
        end
    end

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && !has_match && !has_free) |=>
        (ptr[$past(fill_set)] == WAY_BITS'($past(ptr[fill_set]) + 1'b1)));
endmodule

// File: rtl/dtlb_xlate.sv
// Data translation cache: 16 sets x 4 ways, merged rights, dirty-walk rule,
// single-page invalidate and global-preserving flush. Lookup answers in the
// same cycle from registered state; commands update state at the clock edge.
// Assumes the walker supplies fills for pages it has fully resolved.
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int WAY_BITS = 2,
    localparam int WAYS = 1 << WAY_BITS,
    localparam int SETS = 1 << SET_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VPN_W-1:0]      req_vpn,
    input  logic [OFF_W-1:0]      req_off,
    input  logic                  req_write,
    input  logic                  req_user,
    input  logic                  fill_valid,
    input  logic [VPN_W-1:0]      fill_vpn,
    input  logic [PPN_W-1:0]      fill_ppn,
    input  logic                  fill_global,
    input  logic                  fill_super,
    input  logic                  fill_writable,
    input  logic                  fill_dirty,
    input  logic                  inv_page,
    input  logic [VPN_W-1:0]      inv_vpn,
    input  logic                  flush_all,
    output logic                  hit,
    output logic [PPN_W-1:0]      ppn,
    output logic [PPN_W+OFF_W-1:0] paddr,
    output logic                  fault,
    output logic                  walk_req
);
    entry_t [WAYS-1:0] tbl [SETS];

    logic [SET_BITS-1:0] req_set, fill_set, inv_set;
    logic [WAYS-1:0]     req_oh, fill_oh, inv_oh, fill_empty;
    logic [WAY_BITS-1:0] victim;
    entry_t              req_e, new_e;
    logic                req_any, perm_bad, need_dirty, fill_go, ng_live;

    assign req_set  = req_vpn[SET_BITS-1:0];
    assign fill_set = fill_vpn[SET_BITS-1:0];
    assign inv_set  = inv_vpn[SET_BITS-1:0];
    assign fill_go  = fill_valid && !flush_all && !inv_page;

    dtlb_match #(.WAYS(WAYS)) u_req_match (
        .ways_i(tbl[req_set]), .tag_i(req_vpn[VPN_W-1:SET_BITS]), .hit_oh(req_oh));
    dtlb_match #(.WAYS(WAYS)) u_fill_match (
        .ways_i(tbl[fill_set]), .tag_i(fill_vpn[VPN_W-1:SET_BITS]), .hit_oh(fill_oh));
    dtlb_match #(.WAYS(WAYS)) u_inv_match (
        .ways_i(tbl[inv_set]), .tag_i(inv_vpn[VPN_W-1:SET_BITS]), .hit_oh(inv_oh));

    // free-way mask of the set addressed by the fill
    always_comb begin
        for (int w = 0; w < WAYS; w++) fill_empty[w] = !tbl[fill_set][w].valid;
    end

    dtlb_victim #(.WAY_BITS(WAY_BITS)) u_victim (
        .clk(clk), .rst_n(rst_n), .fill_go(fill_go), .fill_set(fill_set),
        .match_oh(fill_oh), .empty_oh(fill_empty), .way_idx(victim));

    // select the matching request entry
    always_comb begin
        req_e = '0;
        for (int w = 0; w < WAYS; w++)
            if (req_oh[w]) req_e = tbl[req_set][w];
    end

    // classify the request into hit, fault or walk
    always_comb begin
        req_any    = |req_oh;
        perm_bad   = (req_user && req_e.sup) || (req_write && !req_e.wr);
        need_dirty = req_write && !req_e.dirty;
        fault      = req_valid && req_any && perm_bad;
        walk_req   = req_valid && (!req_any || (!perm_bad && need_dirty));
        hit        = req_valid && req_any && !perm_bad && !need_dirty;
        ppn        = hit ? req_e.ppn : '0;
        paddr      = hit ? {req_e.ppn, req_off} : '0;
    end

    // entry image written by a fill
    always_comb begin
        new_e.valid = 1'b1;
        new_e.glob  = fill_global;
        new_e.sup   = fill_super;
        new_e.wr    = fill_writable;
        new_e.dirty = fill_dirty;
        new_e.tag   = fill_vpn[VPN_W-1:SET_BITS];
        new_e.ppn   = fill_ppn;
    end

    // table update: flush over invalidate over fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) tbl[s][w] <= '0;
        end else if (flush_all) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (!tbl[s][w].glob) tbl[s][w].valid <= 1'b0;
        end else if (inv_page) begin
            for (int w = 0; w < WAYS; w++)
                if (inv_oh[w]) tbl[inv_set][w].valid <= 1'b0;
        end else if (fill_valid) begin
            tbl[fill_set][victim] <= new_e;
        end
    end

    // any live non-global entry, for the flush check
    always_comb begin
        ng_live = 1'b0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (tbl[s][w].valid && !tbl[s][w].glob) ng_live = 1'b1;
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !ng_live);
    // R4
    fault_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hit && !walk_req && ppn == '0));
    // R5
    walk_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (!hit && !fault));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!hit && !fault && !walk_req && paddr == '0));
    // R6
    onehot_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_oh));
endmodule

// File: tb/tb_dtlb_xlate.sv
module tb_dtlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_user = 0;
    logic [19:0] req_vpn = '0;
    logic [11:0] req_off = 12'hABC;
    logic        fill_valid = 0, fill_global = 0, fill_super = 0, fill_writable = 0, fill_dirty = 0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0, inv_vpn = '0;
    logic        inv_page = 0, flush_all = 0;
    logic        hit, fault, walk_req;
    logic [19:0] ppn;
    logic [31:0] paddr;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dtlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_off(req_off), .req_write(req_write), .req_user(req_user),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_global(fill_global), .fill_super(fill_super),
        .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .inv_page(inv_page), .inv_vpn(inv_vpn), .flush_all(flush_all),
        .hit(hit), .ppn(ppn), .paddr(paddr), .fault(fault), .walk_req(walk_req));

    task automatic look(input logic [19:0] v, input logic wr, input logic usr,
                        input logic e_hit, input logic [19:0] e_ppn,
                        input logic e_fault, input logic e_walk, input string req);
        logic [31:0] e_pa;
        @(negedge clk);
        req_valid = 1; req_vpn = v; req_write = wr; req_user = usr;
        #1;
        e_pa = e_hit ? {e_ppn, req_off} : 32'h0;
        checks++;
        if (hit !== e_hit || fault !== e_fault || walk_req !== e_walk ||
            ppn !== (e_hit ? e_ppn : 20'h0) || paddr !== e_pa) begin
            errors++;
            $display("FAIL %s vpn=%h: got hit=%b fault=%b walk=%b ppn=%h pa=%h, exp hit=%b fault=%b walk=%b ppn=%h pa=%h",
                     req, v, hit, fault, walk_req, ppn, paddr, e_hit, e_fault, e_walk,
                     e_hit ? e_ppn : 20'h0, e_pa);
        end
        req_valid = 0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic g,
                        input logic s, input logic w, input logic d);
        @(negedge clk);
        fill_valid = 1; fill_vpn = v; fill_ppn = p;
        fill_global = g; fill_super = s; fill_writable = w; fill_dirty = d;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic inval(input logic [19:0] v);
        @(negedge clk); inv_page = 1; inv_vpn = v;
        @(negedge clk); inv_page = 0;
    endtask

    task automatic flush();
        @(negedge clk); flush_all = 1;
        @(negedge clk); flush_all = 0;
    endtask

    task automatic t_reset();
        look(20'h00000, 0, 0, 0, 0, 0, 1, "R1");
        look(20'hFFFFF, 1, 1, 0, 0, 0, 1, "R1");
    endtask

    task automatic t_basic();
        fill(20'h12345, 20'hABCDE, 0, 0, 1, 1);
        look(20'h12345, 0, 1, 1, 20'hABCDE, 0, 0, "R2");
        look(20'h22345, 0, 0, 0, 0, 0, 1, "R3");
        fill(20'h22345, 20'h0F0F0, 0, 0, 1, 1);
        look(20'h22345, 1, 0, 1, 20'h0F0F0, 0, 0, "R2");
        look(20'h12345, 1, 0, 1, 20'hABCDE, 0, 0, "R2");
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_valid = 0; req_vpn = 20'h12345; #1;
        checks++;
        if (hit !== 0 || fault !== 0 || walk_req !== 0 || ppn !== 0 || paddr !== 0) begin
            errors++;
            $display("FAIL R10: hit=%b fault=%b walk=%b ppn=%h pa=%h, exp all 0",
                     hit, fault, walk_req, ppn, paddr);
        end
    endtask

    task automatic t_perm();
        fill(20'h00011, 20'h11111, 0, 1, 1, 1);
        look(20'h00011, 0, 1, 0, 0, 1, 0, "R4");
        look(20'h00011, 0, 0, 1, 20'h11111, 0, 0, "R4");
        fill(20'h00021, 20'h22222, 0, 0, 0, 1);
        look(20'h00021, 1, 0, 0, 0, 1, 0, "R4");
        look(20'h00021, 0, 1, 1, 20'h22222, 0, 0, "R4");
        fill(20'h00061, 20'h66666, 0, 0, 0, 0);
        look(20'h00061, 1, 0, 0, 0, 1, 0, "R4");
    endtask

    task automatic t_dirty();
        fill(20'h00031, 20'h33333, 0, 0, 1, 0);
        look(20'h00031, 0, 1, 1, 20'h33333, 0, 0, "R5");
        look(20'h00031, 1, 1, 0, 0, 0, 1, "R5");
        fill(20'h00031, 20'h33333, 0, 0, 1, 1);
        look(20'h00031, 1, 1, 1, 20'h33333, 0, 0, "R5");
    endtask

    task automatic t_repl();
        for (int i = 0; i < 4; i++)
            fill({16'h0100 + 16'(i), 4'h7}, 20'h70000 + 20'(i), 0, 0, 1, 1);
        for (int i = 0; i < 4; i++)
            look({16'h0100 + 16'(i), 4'h7}, 0, 0, 1, 20'h70000 + 20'(i), 0, 0, "R6");
        fill(20'h01047, 20'h70004, 0, 0, 1, 1);
        look(20'h01007, 0, 0, 0, 0, 0, 1, "R6");
        look(20'h01047, 0, 0, 1, 20'h70004, 0, 0, "R6");
        fill(20'h01057, 20'h70005, 0, 0, 1, 1);
        look(20'h01017, 0, 0, 0, 0, 0, 1, "R6");
        look(20'h01027, 0, 0, 1, 20'h70002, 0, 0, "R6");
        inval(20'h01027);
        fill(20'h01067, 20'h70006, 0, 0, 1, 1);
        look(20'h01037, 0, 0, 1, 20'h70003, 0, 0, "R6");
        look(20'h01067, 0, 0, 1, 20'h70006, 0, 0, "R6");
        fill(20'h01077, 20'h70007, 0, 0, 1, 1);
        look(20'h01067, 0, 0, 0, 0, 0, 1, "R6");
        look(20'h01037, 0, 0, 1, 20'h70003, 0, 0, "R6");
        look(20'h01047, 0, 0, 1, 20'h70004, 0, 0, "R6");
        look(20'h01057, 0, 0, 1, 20'h70005, 0, 0, "R6");
        look(20'h01077, 0, 0, 1, 20'h70007, 0, 0, "R6");
    endtask

    task automatic t_inval();
        fill(20'h00049, 20'h49494, 1, 0, 1, 1);
        look(20'h00049, 0, 0, 1, 20'h49494, 0, 0, "R7");
        inval(20'h00049);
        look(20'h00049, 0, 0, 0, 0, 0, 1, "R7");
    endtask

    task automatic t_flush();
        fill(20'h0004A, 20'h4A4A4, 1, 0, 1, 1);
        fill(20'h0004B, 20'h4B4B4, 0, 0, 1, 1);
        flush();
        look(20'h0004A, 0, 0, 1, 20'h4A4A4, 0, 0, "R8");
        look(20'h0004B, 0, 0, 0, 0, 0, 1, "R8");
        look(20'h12345, 0, 0, 0, 0, 0, 1, "R8");
    endtask

    task automatic t_prio();
        fill(20'h0004C, 20'h4C4C4, 0, 0, 1, 1);
        @(negedge clk);
        inv_page = 1; inv_vpn = 20'h0004C;
        fill_valid = 1; fill_vpn = 20'h0005C; fill_ppn = 20'h5C5C5;
        fill_global = 0; fill_super = 0; fill_writable = 1; fill_dirty = 1;
        @(negedge clk);
        inv_page = 0; fill_valid = 0;
        look(20'h0004C, 0, 0, 0, 0, 0, 1, "R9");
        look(20'h0005C, 0, 0, 0, 0, 0, 1, "R9");
        fill(20'h0004D, 20'h4D4D4, 1, 0, 1, 1);
        @(negedge clk);
        flush_all = 1; inv_page = 1; inv_vpn = 20'h0004D;
        @(negedge clk);
        flush_all = 0; inv_page = 0;
        look(20'h0004D, 0, 0, 1, 20'h4D4D4, 0, 0, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_basic();
        t_idle();
        t_perm();
        t_dirty();
        t_repl();
        t_inval();
        t_flush();
        t_prio();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got hang, exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule